// File: doc/BRIEF.md
# SPI Register-Access Frame Engine

This block is an SPI master that reads and writes registers in a peripheral. Each access is one frame with three parts: a 16-bit register offset, a control byte, and one or more data bytes. The host pulses `start` with the offset, a 5-bit block select, a direction flag, an operation mode and a byte count. The engine then clocks the whole frame out in SPI mode 0. Write bytes are pulled from the host one at a time through a ready strobe. Read bytes come back on a byte output with a one-cycle valid flag. A one-cycle `done` pulse closes every accepted request.

Two chip-select framing styles are available. In variable-length mode each frame is bounded by chip select, and one frame may carry any number of data bytes. In the fixed-length modes every frame carries exactly 1, 2 or 4 data bytes. Chip select is pulled low and then left low, so the peripheral finds frame boundaries by counting bytes. The serial clock runs at the system clock divided by 2×(DIV+1).

Top module: `spi_frame_engine`

## Requirements
- R1: The first two bytes of every frame carry the register offset: bits [15:8] first, then bits [7:0].
- R2: The third byte is the control byte: bits [7:3] are the block select, bit 2 is the direction (1 = write, 0 = read) and bits [1:0] are the operation mode.
- R3: Mode 00 is variable length with 1 to 2^CNT_W−1 data bytes. `cs_n` falls before the first SCLK rise of the frame and rises after the last data byte. A count of 0 in this mode is rejected.
- R4: Modes 01, 10 and 11 carry exactly 1, 2 and 4 data bytes. A fixed-length frame drives `cs_n` low, never raises it during the frame, and leaves it low after `done`.
- R5: A request whose count does not fit its mode is rejected. `done` and `err` are both high in the cycle after the start strobe, `busy` stays low, and no SCLK edge is produced.
- R6: In a write, the data bytes on MOSI are the successive `wdata` values that were present while `wdata_ready` was high, in order.
- R7: In a read, each data slot drives 0x00 on MOSI. Each received byte appears on `rdata` with a one-cycle `rdata_valid`, in order. Bytes received during the offset, control and write slots are never delivered.
- R8: SCLK idles low. MOSI changes only while SCLK is low. MISO is sampled on the rising edge, MSB first. Every SCLK high phase lasts DIV+1 system cycles.
- R9: Before a variable-length frame, `cs_n` is high for at least 2×(DIV+1) system cycles.
- R10: `busy` is high from an accepted start until `done`. A start strobe that arrives while `busy` is high has no effect on the frame in progress.
- R11: `done` is a single-cycle pulse, issued once for each start strobe accepted in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| offset | input | 16 | Register offset |
| blk_sel | input | 5 | Block select |
| wr_rq | input | 1 | 1 = write access, 0 = read access |
| op_mode | input | 2 | Operation mode (00 variable, 01/10/11 fixed 1/2/4) |
| byte_cnt | input | CNT_W | Number of data bytes |
| wdata | input | 8 | Write data byte on offer |
| wdata_ready | output | 1 | Engine takes `wdata` at this clock edge |
| rdata | output | 8 | Received read byte |
| rdata_valid | output | 1 | `rdata` holds a new byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request rejected (with `done`) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to peripheral |
| miso | input | 1 | Serial data from peripheral |
| cs_n | output | 1 | Chip select, active low |

## Verification
The assertions assume that `start` is pulsed with request fields that are stable in the accepting cycle. They also assume that `wdata` holds the byte for the next write slot whenever `wdata_ready` can rise. The stimulus changes `wdata` only on the falling clock edge after the engine took a byte. It changes `start` and the request fields only on falling edges, and it deliberately pulses `start` once more in the middle of some frames with unrelated fields. The peripheral model on the bench changes MISO only on SCLK falling edges. In fixed-length mode it finds frame ends by counting bytes, as a real device must.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;

    localparam int unsigned OFF_W     = 16;
    localparam int unsigned BLK_W     = 5;
    localparam int unsigned HDR_BYTES = 3;

    typedef enum logic [1:0] {
        OPM_VAR  = 2'b00,
        OPM_FIX1 = 2'b01,
        OPM_FIX2 = 2'b10,
        OPM_FIX4 = 2'b11
    } opmode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_LOAD,
        ST_XFER
    } seq_st_e;

    // control byte: field order is the wire order, MSB first
    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic             wr;
        opmode_e          mode;
    } ctrl_t;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        ctrl_t            ctrl;
    } hdr_t;

    // data bytes per frame in the fixed modes, 0 for variable mode
    function automatic logic [3:0] fixed_len(opmode_e m);
        case (m)
            OPM_FIX1: return 4'd1;
            OPM_FIX2: return 4'd2;
            OPM_FIX4: return 4'd4;
            default:  return 4'd0;
        endcase
    endfunction

    function automatic logic [7:0] hdr_byte(hdr_t h, logic [1:0] slot);
        case (slot)
            2'd0:    return h.off[15:8];
            2'd1:    return h.off[7:0];
            default: return h.ctrl;
        endcase
    endfunction

endpackage

// File: rtl/spi_frm_tick.sv
module spi_frm_tick #(
    parameter int unsigned DIV = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = $clog2(DIV + 2);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/spi_frm_shift.sv
module spi_frm_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] tx,
    input  logic       tick,
    input  logic       miso,
    output logic       active,
    output logic       byte_done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi
);
    logic [7:0] sr;
    logic [2:0] bitn;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr        <= '0;
            rx        <= '0;
            bitn      <= '0;
            sclk      <= 1'b0;
            active    <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (load && !active) begin
                sr     <= tx;
                bitn   <= '0;
                sclk   <= 1'b0;
                active <= 1'b1;
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        sr   <= {sr[6:0], 1'b0};
                        bitn <= bitn + 3'd1;
                    end
                end
            end
        end
    end

    assign mosi = sr[7];

    // R8
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sclk);

    // R8
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));
endmodule

// File: rtl/spi_frm_seq.sv
module spi_frm_seq
    import spi_frm_pkg::*;
#(
    parameter int unsigned CNT_W = 4,
    parameter logic [7:0]  DUMMY = 8'h00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      offset,
    input  logic [4:0]       blk_sel,
    input  logic             wr_rq,
    input  logic [1:0]       op_mode,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [7:0]       wdata,
    input  logic             sh_done,
    input  logic [7:0]       sh_rx,
    input  logic             tick,
    output logic             sh_load,
    output logic [7:0]       sh_tx,
    output logic             tick_clr,
    output logic             gap_run,
    output logic             cs_n,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             wdata_ready,
    output logic [7:0]       rdata,
    output logic             rdata_valid
);
    localparam int unsigned SW = CNT_W + 2;

    seq_st_e          st;
    hdr_t             hdr;
    logic [CNT_W-1:0] cnt_q;
    logic [SW-1:0]    slot;
    logic             gap_half;

    opmode_e req_mode;
    logic    req_bad;
    logic    is_data;
    logic    last_slot;

    assign req_mode  = opmode_e'(op_mode);
    assign req_bad   = (byte_cnt == '0) ||
                       ((req_mode != OPM_VAR) && (byte_cnt != CNT_W'(fixed_len(req_mode))));
    assign is_data   = (slot >= SW'(HDR_BYTES));
    assign last_slot = (slot == SW'(cnt_q) + SW'(HDR_BYTES - 1));

    assign busy        = (st != ST_IDLE);
    assign gap_run     = (st == ST_GAP);
    assign tick_clr    = (st == ST_IDLE);
    assign sh_load     = (st == ST_LOAD);
    assign wdata_ready = (st == ST_LOAD) && is_data && hdr.ctrl.wr;
    assign sh_tx       = !is_data      ? hdr_byte(hdr, slot[1:0]) :
                         hdr.ctrl.wr   ? wdata : DUMMY;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            hdr         <= '0;
            cnt_q       <= '0;
            slot        <= '0;
            gap_half    <= 1'b0;
            cs_n        <= 1'b1;
            done        <= 1'b0;
            err         <= 1'b0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            done        <= 1'b0;
            err         <= 1'b0;
            rdata_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (req_bad) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else begin
                            hdr.off       <= offset;
                            hdr.ctrl.blk  <= blk_sel;
                            hdr.ctrl.wr   <= wr_rq;
                            hdr.ctrl.mode <= req_mode;
                            cnt_q         <= byte_cnt;
                            slot          <= '0;
                            gap_half      <= 1'b0;
                            if (req_mode == OPM_VAR) begin
                                cs_n <= 1'b1;
                                st   <= ST_GAP;
                            end else begin
                                cs_n <= 1'b0;
                                st   <= ST_LOAD;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            cs_n <= 1'b0;
                            st   <= ST_LOAD;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    st <= ST_XFER;
                end
                ST_XFER: begin
                    if (sh_done) begin
                        if (is_data && !hdr.ctrl.wr) begin
                            rdata       <= sh_rx;
                            rdata_valid <= 1'b1;
                        end
                        if (last_slot) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                            if (hdr.ctrl.mode == OPM_VAR) cs_n <= 1'b1;
                        end else begin
                            slot <= slot + SW'(1);
                            st   <= ST_LOAD;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5
    err_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    rd_only_chk: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> !hdr.ctrl.wr);

    // R6
    wr_pull_chk: assert property (@(posedge clk) disable iff (rst)
        wdata_ready |-> (hdr.ctrl.wr && busy));

    // R4
    fix_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !err && (hdr.ctrl.mode != OPM_VAR)) |-> !cs_n);

    // R10
    busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(hdr));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
    parameter int unsigned DIV   = 1,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      offset,
    input  logic [4:0]       blk_sel,
    input  logic             wr_rq,
    input  logic [1:0]       op_mode,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [7:0]       wdata,
    output logic             wdata_ready,
    output logic [7:0]       rdata,
    output logic             rdata_valid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    logic       sh_load, sh_active, sh_done;
    logic [7:0] sh_tx, sh_rx;
    logic       tick, seq_tick_clr, gap_run;

    spi_frm_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (seq_tick_clr || sh_load),
        .en   (sh_active || gap_run),
        .tick (tick)
    );

    spi_frm_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .tx        (sh_tx),
        .tick      (tick),
        .miso      (miso),
        .active    (sh_active),
        .byte_done (sh_done),
        .rx        (sh_rx),
        .sclk      (sclk),
        .mosi      (mosi)
    );

    spi_frm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .offset      (offset),
        .blk_sel     (blk_sel),
        .wr_rq       (wr_rq),
        .op_mode     (op_mode),
        .byte_cnt    (byte_cnt),
        .wdata       (wdata),
        .sh_done     (sh_done),
        .sh_rx       (sh_rx),
        .tick        (tick),
        .sh_load     (sh_load),
        .sh_tx       (sh_tx),
        .tick_clr    (seq_tick_clr),
        .gap_run     (gap_run),
        .cs_n        (cs_n),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .wdata_ready (wdata_ready),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    // R3
    cs_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !cs_n);
endmodule

// File: tb/sim_spi_frame_engine.sv
module sim_spi_frame_engine;
    localparam int DIV   = 1;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             start = 1'b0;
    logic [15:0]      offset = '0;
    logic [4:0]       blk_sel = '0;
    logic             wr_rq = 1'b0;
    logic [1:0]       op_mode = '0;
    logic [CNT_W-1:0] byte_cnt = '0;
    logic [7:0]       wdata = '0;
    logic             wdata_ready, rdata_valid, busy, done, err, sclk, mosi, cs_n;
    logic [7:0]       rdata;
    logic             miso = 1'b1;

    spi_frame_engine #(.DIV(DIV), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .offset(offset), .blk_sel(blk_sel),
        .wr_rq(wr_rq), .op_mode(op_mode), .byte_cnt(byte_cnt), .wdata(wdata),
        .wdata_ready(wdata_ready), .rdata(rdata), .rdata_valid(rdata_valid),
        .busy(busy), .done(done), .err(err), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int flen(input logic [1:0] m);
        case (m)
            2'd1: return 1;
            2'd2: return 2;
            2'd3: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int mi(input logic [15:0] a, input logic [4:0] b);
        return int'({b[0], a[4:0]});
    endfunction

    // ---------------- peripheral model ----------------
    logic [7:0] smem [64];
    logic [7:0] ref_mem [64];
    logic [7:0] cap [32];
    int         cap_n = 0;
    int         sclk_rises = 0;
    int         cs_rises = 0;
    int         sbit = 0;
    int         fb = 0;
    logic [7:0] srx = '0, stx = '0, spend = 8'hA5, sctl = '0;
    logic [15:0] sa = '0;

    always @(posedge cs_n) begin
        cs_rises++;
        fb = 0; sbit = 0; spend = 8'hA5;
    end

    always @(negedge cs_n) begin
        fb = 0; sbit = 0; stx = spend; miso = stx[7];
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (sbit == 0) stx = spend;
            else           stx = {stx[6:0], 1'b0};
            miso = stx[7];
        end
    end

    always @(posedge sclk) begin
        sclk_rises++;
        if (!cs_n) begin
            srx = {srx[6:0], mosi};
            sbit++;
            if (sbit == 8) begin
                sbit = 0;
                if (cap_n < 32) cap[cap_n] = srx;
                cap_n++;
                case (fb)
                    0: sa[15:8] = srx;
                    1: sa[7:0]  = srx;
                    2: sctl     = srx;
                    default: if (sctl[2]) smem[mi(sa + 16'(fb - 3), sctl[7:3])] = srx;
                endcase
                fb++;
                if (fb >= 3 && sctl[1:0] != 2'b00 && fb == 3 + flen(sctl[1:0])) fb = 0;
                if (fb >= 3 && !sctl[2]) spend = smem[mi(sa + 16'(fb - 3), sctl[7:3])];
                else                     spend = 8'hA5;
            end
        end
    end

    // ---------------- timing monitors ----------------
    int hi_sclk = 0;
    int hi_cs = 0;
    bit cur_var = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (sclk) hi_sclk++;
            else if (hi_sclk != 0) begin
                chk(hi_sclk == DIV + 1, "R8 sclk high phase", hi_sclk, DIV + 1);
                hi_sclk = 0;
            end
            if (cs_n) hi_cs++;
            else begin
                if (hi_cs != 0 && cur_var)
                    chk(hi_cs >= 2 * (DIV + 1), "R9 cs_n gap", hi_cs, 2 * (DIV + 1));
                hi_cs = 0;
            end
        end
    end

    // ---------------- frame driver ----------------
    task automatic run_frame(input logic [15:0] off, input logic [4:0] blk, input bit wr,
                             input logic [1:0] md, input int n, input bit poke);
        logic [7:0] wb [16];
        logic [7:0] rb [16];
        int  widx = 0, ridx = 0, tmo = 0, rises0, csr0;
        bit  prev_rdy = 1'b0, exp_err;
        exp_err = (n == 0) || (md != 2'b00 && n != flen(md));
        for (int i = 0; i < 16; i++) wb[i] = 8'($urandom);
        @(negedge clk);
        offset = off; blk_sel = blk; wr_rq = wr; op_mode = md; byte_cnt = CNT_W'(n);
        wdata = wb[0]; cap_n = 0; cur_var = (md == 2'b00);
        rises0 = sclk_rises; csr0 = cs_rises;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (exp_err) begin
            chk(done && err, "R5 reject done/err", {done, err}, 2'b11);
            chk(!busy, "R5 busy stays low", busy, 0);
            repeat (6) @(negedge clk);
            chk(sclk_rises == rises0, "R5 no sclk edge", sclk_rises - rises0, 0);
            return;
        end
        chk(busy && !done, "R10 busy after start", {busy, done}, 2'b10);
        forever begin
            @(negedge clk);
            if (prev_rdy) widx++;
            wdata = wb[widx & 15];
            prev_rdy = wdata_ready;
            if (rdata_valid) begin
                if (ridx < 16) rb[ridx] = rdata;
                ridx++;
            end
            if (poke && tmo == 40) begin
                start = 1'b1; offset = ~off; blk_sel = ~blk; wr_rq = ~wr;
                op_mode = 2'b00; byte_cnt = CNT_W'(1);
            end
            if (poke && tmo == 41) start = 1'b0;
            if (done) break;
            tmo++;
            if (tmo > 20000) begin
                chk(1'b0, "R11 frame never finished", tmo, 0);
                return;
            end
        end
        chk(!err, "R5 err on legal request", err, 0);
        chk(cap_n == 3 + n, "R3/R4 byte slots", cap_n, 3 + n);
        chk(cap[0] == off[15:8], "R1 offset high byte", cap[0], off[15:8]);
        chk(cap[1] == off[7:0], "R1 offset low byte", cap[1], off[7:0]);
        chk(cap[2] == {blk, wr, md}, "R2 control byte", cap[2], {blk, wr, md});
        if (wr) begin
            chk(widx == n - 1 || widx == n, "R6 bytes pulled", widx, n);
            chk(ridx == 0, "R7 no rdata on write", ridx, 0);
            for (int i = 0; i < n; i++) begin
                chk(cap[3 + i] == wb[i], "R6 write byte", cap[3 + i], wb[i]);
                ref_mem[mi(off + 16'(i), blk)] = wb[i];
            end
        end else begin
            chk(ridx == n, "R7 read byte count", ridx, n);
            for (int i = 0; i < n; i++) begin
                chk(cap[3 + i] == 8'h00, "R7 dummy on MOSI", cap[3 + i], 0);
                chk(rb[i] == ref_mem[mi(off + 16'(i), blk)], "R7 read byte",
                    rb[i], ref_mem[mi(off + 16'(i), blk)]);
            end
        end
        if (md == 2'b00) chk(cs_n == 1'b1, "R3 cs_n high at end", cs_n, 1);
        else begin
            chk(cs_n == 1'b0, "R4 cs_n left low", cs_n, 0);
            chk(cs_rises == csr0, "R4 no cs_n toggle", cs_rises - csr0, 0);
        end
        @(negedge clk);
        chk(!done && !busy, "R11 single done pulse", {done, busy}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin
            smem[i]    = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && !sclk && !busy && !done && !err, "R8 reset state",
            {cs_n, sclk, busy, done, err}, 5'b10000);

        // directed: six-byte hardware address in the common block, then read back
        run_frame(16'h0009, 5'd0, 1'b1, 2'b00, 6, 1'b0);
        run_frame(16'h0009, 5'd0, 1'b0, 2'b00, 6, 1'b0);
        // fixed-length modes, back to back with cs_n held low
        run_frame(16'h0003, 5'd1, 1'b1, 2'b01, 1, 1'b0);
        run_frame(16'h0004, 5'd1, 1'b1, 2'b10, 2, 1'b0);
        run_frame(16'h0008, 5'd1, 1'b1, 2'b11, 4, 1'b0);
        run_frame(16'h0003, 5'd1, 1'b0, 2'b11, 4, 1'b0);
        // rejected requests
        run_frame(16'h0010, 5'd0, 1'b1, 2'b10, 3, 1'b0);
        run_frame(16'h0010, 5'd0, 1'b0, 2'b01, 4, 1'b0);
        run_frame(16'h0010, 5'd0, 1'b1, 2'b00, 0, 1'b0);
        // variable after fixed, maximum length, start while busy
        run_frame(16'h0100, 5'd2, 1'b1, 2'b00, 15, 1'b1);
        run_frame(16'h0100, 5'd2, 1'b0, 2'b00, 15, 1'b1);

        for (int k = 0; k < 40; k++) begin
            logic [1:0] md;
            int n;
            md = 2'($urandom);
            if (md == 2'b00) n = 1 + int'($urandom % 8);
            else if ($urandom % 5 == 0) n = int'($urandom % 6);
            else n = flen(md);
            run_frame(16'($urandom % 40), 5'($urandom), 1'($urandom), md, n,
                      ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule